// File: doc/BRIEF.md
# Escalating System Watchdog Timer

This block is a 32-bit down-counting watchdog that is already running when reset is released. Software must service it before the count runs out. A service is a write of two fixed key words, in order, to the service address. If the count expires, the block either raises its system reset output at once, or escalates in two stages. In the two-stage case, the first expiry raises a non-maskable interrupt and reloads the count. A second expiry with no service in between raises system reset.

Software configures the reload value, the count source and the expiry action through a small write-only register port. The count advances on every system clock edge, or once per rising edge of a slower crystal clock that is sampled into the system clock domain. Setting a lock bit freezes the configuration until the next reset. Both outputs are level signals that stay asserted until they are cleared: the interrupt by a valid service, the reset output only by `rst_n`.

Top module: `wdt_escalate`

## Requirements
- R1: After `rst_n` rises, with no write at all, the count starts from `RST_TIMEOUT`. Both outputs are low, the action is direct reset and the source is the system clock. `sys_rst_o` goes high on the (`RST_TIMEOUT`+1)-th rising system clock edge after release.
- R2: In direct mode (control bit 1 = 0), expiry raises `sys_rst_o` and leaves `nmi_o` low. `sys_rst_o` then stays high until `rst_n` falls, whatever is written.
- R3: In escalating mode (control bit 1 = 1), the first expiry raises `nmi_o` and reloads the count from the timeout register. A second expiry with `nmi_o` still high raises `sys_rst_o`.
- R4: A valid service is a write of `KEY_A` to address 2, followed directly by a write of `KEY_B` to address 2. It reloads the count from the timeout register on the edge that takes `KEY_B`, and it clears `nmi_o`.
- R5: Any other write breaks the key sequence and does not reload the count. This covers a write to another address, a wrong value, `KEY_B` without a preceding `KEY_A`, and `KEY_A` twice.
- R6: Writing control bit 2 = 1 sets the lock. Once locked, writes to the timeout register (address 0) and to the control register (address 1) are ignored. Only `rst_n` clears the lock.
- R7: With control bit 0 = 1, the count moves once per rising edge of `clk_xtal` instead of once per system clock edge.
- R8: If a valid service lands on the same edge as an expiry, the service wins: the count reloads and no output rises.
- R9: A write to the timeout register does not change the running count. The new value is used from the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock; all state is in this domain |
| clk_xtal | input | 1 | Crystal clock, sampled as a count source |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 timeout, 1 control, 2 service, 3 unused |
| wr_data | input | CW | Write data |
| nmi_o | output | 1 | First-stage non-maskable interrupt |
| sys_rst_o | output | 1 | System reset request, held until `rst_n` |

## Verification
An expiry and a valid service can meet on the same system clock edge. The bench provokes this by waiting `RST_TIMEOUT`-1 cycles after reset before it writes the two keys, so that `KEY_B` is taken on exactly the edge where the count would expire. It then judges that `sys_rst_o` stays low and that the next expiry comes a full timeout period later. A property in the bound checker also requires that `sys_rst_o` never rises on the edge after a valid service.

// File: rtl/wdt_escalate.sv
module wdt_escalate #(
  parameter int CW = 32,
  parameter logic [CW-1:0] RST_TIMEOUT = 32'd1_000_000,
  parameter logic [CW-1:0] KEY_A = 32'h5A5A_1234,
  parameter logic [CW-1:0] KEY_B = 32'hA5A5_4321
) (
  input  logic          clk_sys,
  input  logic          clk_xtal,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          nmi_o,
  output logic          sys_rst_o
);

  localparam logic [1:0] A_TMO = 2'd0;
  localparam logic [1:0] A_CTL = 2'd1;
  localparam logic [1:0] A_SVC = 2'd2;

  logic [CW-1:0] timeout_q, cnt_q;
  logic          sel_q, mode_q, lock_q, armed_q;
  logic [2:0]    xs_q;

  wire is_svc = wr_en && (wr_addr == A_SVC);
  wire svc_ok = is_svc && (wr_data == KEY_B) && armed_q && !sys_rst_o;
  wire cfg_we = wr_en && !lock_q;
  wire tick   = sel_q ? (xs_q[1] & ~xs_q[2]) : 1'b1;
  wire expire = tick && (cnt_q == '0) && !sys_rst_o;

  always_ff @(posedge clk_sys or negedge rst_n)
    if (!rst_n) xs_q <= '0;
    else        xs_q <= {xs_q[1:0], clk_xtal};

  always_ff @(posedge clk_sys or negedge rst_n)
    if (!rst_n) begin
      timeout_q <= RST_TIMEOUT;
      sel_q     <= 1'b0;
      mode_q    <= 1'b0;
      lock_q    <= 1'b0;
    end else if (cfg_we) begin
      if (wr_addr == A_TMO) timeout_q <= wr_data;
      if (wr_addr == A_CTL) begin
        sel_q  <= wr_data[0];
        mode_q <= wr_data[1];
        lock_q <= wr_data[2];
      end
    end

  always_ff @(posedge clk_sys or negedge rst_n)
    if (!rst_n)     armed_q <= 1'b0;
    else if (wr_en) armed_q <= is_svc && (wr_data == KEY_A);

  always_ff @(posedge clk_sys or negedge rst_n)
    if (!rst_n) begin
      cnt_q     <= RST_TIMEOUT;
      nmi_o     <= 1'b0;
      sys_rst_o <= 1'b0;
    end else if (svc_ok) begin
      cnt_q <= timeout_q;
      nmi_o <= 1'b0;
    end else if (expire) begin
      if (mode_q && !nmi_o) begin
        nmi_o <= 1'b1;
        cnt_q <= timeout_q;
      end else begin
        sys_rst_o <= 1'b1;
      end
    end else if (tick && !sys_rst_o) begin
      cnt_q <= cnt_q - 1'b1;
    end

endmodule

module wdt_escalate_chk #(parameter int CW = 32) (
  input logic          clk_sys,
  input logic          rst_n,
  input logic          nmi_o,
  input logic          sys_rst_o,
  input logic          mode_q,
  input logic          lock_q,
  input logic          sel_q,
  input logic          svc_ok,
  input logic [CW-1:0] timeout_q
);

  a_r2_reset_held: assert property (@(posedge clk_sys) disable iff (!rst_n)
    sys_rst_o |=> sys_rst_o);

  a_r3_nmi_first: assert property (@(posedge clk_sys) disable iff (!rst_n)
    ($rose(sys_rst_o) && $past(mode_q)) |-> $past(nmi_o));

  a_r4_service_clears: assert property (@(posedge clk_sys) disable iff (!rst_n)
    svc_ok |=> !nmi_o);

  a_r6_lock_held: assert property (@(posedge clk_sys) disable iff (!rst_n)
    lock_q |=> lock_q);

  a_r6_cfg_frozen: assert property (@(posedge clk_sys) disable iff (!rst_n)
    lock_q |=> ($stable(timeout_q) && $stable(mode_q) && $stable(sel_q)));

  a_r8_service_wins: assert property (@(posedge clk_sys) disable iff (!rst_n)
    svc_ok |=> !$rose(sys_rst_o));

endmodule

bind wdt_escalate wdt_escalate_chk #(.CW(CW)) u_chk (
  .clk_sys(clk_sys), .rst_n(rst_n), .nmi_o(nmi_o), .sys_rst_o(sys_rst_o),
  .mode_q(mode_q), .lock_q(lock_q), .sel_q(sel_q), .svc_ok(svc_ok),
  .timeout_q(timeout_q)
);

// File: tb/test_wdt_escalate.sv
module test_wdt_escalate;
  localparam int CW = 32;
  localparam int T  = 16;
  localparam logic [31:0] KA = 32'h5A5A_1234;
  localparam logic [31:0] KB = 32'hA5A5_4321;

  logic clk = 0, xclk = 0, rst_n = 0, wr_en = 0;
  logic [1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic nmi, srst;
  int errors = 0, checks = 0;

  always #2  clk  = ~clk;
  always #20 xclk = ~xclk;

  wdt_escalate #(.CW(CW), .RST_TIMEOUT(T), .KEY_A(KA), .KEY_B(KB)) i_wdt_escalate (
    .clk_sys(clk), .clk_xtal(xclk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .nmi_o(nmi), .sys_rst_o(srst));

  // {addr1, data1, addr2, data2, reload expected}
  localparam logic [68:0] VEC [0:6] = '{
    {2'd2, KA, 2'd2, KB, 1'b1},
    {2'd2, KB, 2'd2, KA, 1'b0},
    {2'd2, KA, 2'd3, 32'd0, 1'b0},
    {2'd2, KA, 2'd2, KA, 1'b0},
    {2'd2, KA, 2'd2, KB ^ 32'd1, 1'b0},
    {2'd1, 32'd0, 2'd2, KB, 1'b0},
    {2'd0, 32'd16, 2'd2, KB, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_en = 0;
    wait_n(2);
    rst_n = 1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic service();
    wr(2'd2, KA);
    wr(2'd2, KB);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    foreach (VEC[i]) begin
      do_reset();
      wr(VEC[i][68:67], VEC[i][66:35]);
      wr(VEC[i][34:33], VEC[i][32:1]);
      wait_n(T - 1);
      check($sformatf("R4/R5 vector %0d", i), {31'd0, srst}, {31'd0, !VEC[i][0]});
    end

    // R1 reset state and default timing; R2 direct and sticky
    do_reset();
    check("R1 nmi after reset", {31'd0, nmi}, 0);
    check("R1 rst after reset", {31'd0, srst}, 0);
    wait_n(T);
    check("R1 no early expiry", {31'd0, srst}, 0);
    wait_n(1);
    check("R1 expiry on time", {31'd0, srst}, 1);
    check("R2 direct leaves nmi low", {31'd0, nmi}, 0);
    wait_n(5);
    service();
    check("R2 reset held", {31'd0, srst}, 1);

    // R3 escalation
    do_reset();
    wr(2'd1, 32'd2);
    wait_n(T - 1);
    check("R3 no nmi early", {31'd0, nmi}, 0);
    wait_n(1);
    check("R3 first expiry nmi", {31'd0, nmi}, 1);
    check("R3 first expiry no rst", {31'd0, srst}, 0);
    wait_n(T);
    check("R3 reload then no rst", {31'd0, srst}, 0);
    wait_n(1);
    check("R3 second expiry rst", {31'd0, srst}, 1);

    // R4 service clears nmi and reloads
    do_reset();
    wr(2'd1, 32'd2);
    wait_n(T);
    check("R4 nmi pending", {31'd0, nmi}, 1);
    service();
    check("R4 nmi cleared", {31'd0, nmi}, 0);
    wait_n(T);
    check("R4 reloaded count", {31'd0, nmi | srst}, 0);
    wait_n(1);
    check("R4 fresh first stage", {30'd0, srst, nmi}, 1);

    // R6 lock
    do_reset();
    wr(2'd1, 32'd4);
    wr(2'd0, 32'd100);
    wr(2'd1, 32'd2);
    service();
    wait_n(T);
    check("R6 locked timeout kept", {31'd0, srst}, 0);
    wait_n(1);
    check("R6 locked mode kept", {30'd0, srst, nmi}, 2);
    do_reset();
    wr(2'd1, 32'd2);
    wait_n(T);
    check("R6 lock cleared by reset", {30'd0, srst, nmi}, 1);

    // R9 timeout takes effect at next reload
    do_reset();
    wr(2'd0, 32'd30);
    wait_n(T - 1);
    check("R9 running count unchanged", {31'd0, srst}, 0);
    wait_n(1);
    check("R9 old count expires", {31'd0, srst}, 1);
    do_reset();
    wr(2'd0, 32'd30);
    service();
    wait_n(30);
    check("R9 new value after reload", {31'd0, srst}, 0);
    wait_n(1);
    check("R9 new value expires", {31'd0, srst}, 1);

    // R8 service on the expiry edge
    do_reset();
    wait_n(T - 1);
    service();
    check("R8 service beats expiry", {31'd0, srst}, 0);
    wait_n(T);
    check("R8 full period after", {31'd0, srst}, 0);
    wait_n(1);
    check("R8 next expiry", {31'd0, srst}, 1);

    // R7 crystal clock source
    do_reset();
    wr(2'd1, 32'd1);
    wait_n(3 * T);
    check("R7 slow source no early expiry", {31'd0, srst}, 0);
    begin
      int c = 3 * T;
      while (!srst && c < 400) begin
        wait_n(1);
        c++;
      end
      check("R7 expiry window", {31'd0, (c >= 140 && c <= 200)}, 1);
    end

    report();
  end
endmodule